// File: doc/BRIEF.md
# Coincident Matrix Line Selector with Multi-Drive Detector

This block picks one drive line out of a rectangular array of lines. It does not give every line its own enable. It splits the line address into a row part and a column part. Each part drives one group of driver enables, one-hot within the group. A line is energised only where an active row driver (the "high" end) meets an active column driver (the "low" end). With 8 row and 8 column drivers, 16 enables cover 64 lines. With 16 row and 8 column drivers, the same structure covers 128 lines.

The block also produces the full line-select vector as a reference output, so that downstream logic or a bench can see which line the driver pair reaches. A drive-enable input gates the whole pulse. A separate detector watches each driver group for two or more active enables. It records any such event in a sticky, registered error flag, so that a one-cycle double drive is still visible later. A force input can add extra enables to either group while driving is enabled, so the detector can be exercised on purpose.

Top module: `matrix_line_sel`

## Requirements
- R1: With `drive_en` = 1 and both force inputs zero, `hi_drv` has only bit `addr / LO_N` set and `lo_drv` has only bit `addr % LO_N` set. The row index is taken from the upper address bits and the column index from the lowest log2(LO_N) bits.
- R2: `line_sel[i]` is 1 exactly when `hi_drv[i / LO_N]` and `lo_drv[i % LO_N]` are both 1. With a single driver pair, only bit `addr` (row*LO_N + column) is set.
- R3: With `drive_en` = 0, `hi_drv`, `lo_drv` and `line_sel` are all zero whatever `addr`, `force_hi` and `force_lo` hold, and no error flag is set by that stimulus.
- R4: With `drive_en` = 1, each bit of `force_hi` / `force_lo` is OR-ed into the matching bit of `hi_drv` / `lo_drv`.
- R5: `err_hi` becomes 1 one clock edge after an edge at which two or more bits of `hi_drv` were 1.
- R6: `err_lo` becomes 1 one clock edge after an edge at which two or more bits of `lo_drv` were 1, and the row flag is not affected by it.
- R7: An error flag stays 1 until `err_clr` is sampled high. If a multi-drive occurs in the same cycle as the clear, the set wins.
- R8: After reset both error flags are 0, and a flag never rises without a preceding multi-drive in its group.
- R9: A configuration with HI_N = 16 and LO_N = 8 takes a 7-bit address and maps each of its 128 addresses to a distinct single line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Line address, row part above column part |
| drive_en | input | 1 | Gates all driver enables |
| force_hi | input | HI_N | Extra row enables injected for detector test |
| force_lo | input | LO_N | Extra column enables injected for detector test |
| err_clr | input | 1 | Clears the sticky error flags |
| hi_drv | output | HI_N | Row ("high") driver enables |
| lo_drv | output | LO_N | Column ("low") driver enables |
| line_sel | output | LINES | Reference vector of energised lines |
| err_hi | output | 1 | Sticky flag: two or more row drivers were active |
| err_lo | output | 1 | Sticky flag: two or more column drivers were active |

## Verification
The bench builds two instances: the default 8×8 array and a 16×8 array. That makes every address of both the 64-line and the 128-line layouts small enough to sweep exhaustively, with the expected row, column and line bits computed by division and remainder. On the 8×8 instance, forced extra enables reach the detector in both groups. This exercises the latching delay, the hold after the fault goes away, the clear, the set-over-clear collision, and the gating of forced enables while driving is disabled.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int MAXW = 64;

  // True when two or more bits of v are set.
  function automatic logic multi_hot(input logic [MAXW-1:0] v);
    return (v & (v - MAXW'(1))) != '0;
  endfunction

  // Row index of a linear line address.
  function automatic int unsigned row_of(input int unsigned line, input int unsigned cols);
    return line / cols;
  endfunction

  // Column index of a linear line address.
  function automatic int unsigned col_of(input int unsigned line, input int unsigned cols);
    return line % cols;
  endfunction
endpackage

// File: rtl/mls_group_dec.sv
module mls_group_dec #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  logic [N-1:0]  force_v,
  output logic [N-1:0]  drv
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign drv[g] = en & ((idx == IW'(g)) | force_v[g]);
  end
endmodule

// File: rtl/mls_multi_det.sv
module mls_multi_det
  import mls_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] drv,
  input  logic         clr,
  output logic         multi,
  output logic         err
);
  assign multi = multi_hot(MAXW'(drv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= multi | (err & ~clr);
  end
endmodule

// File: rtl/mls_line_matrix.sv
module mls_line_matrix #(
  parameter int HI_N = 8,
  parameter int LO_N = 8,
  localparam int LINES = HI_N * LO_N
) (
  input  logic [HI_N-1:0]  hi,
  input  logic [LO_N-1:0]  lo,
  output logic [LINES-1:0] line
);
  for (genvar h = 0; h < HI_N; h++) begin : g_row
    for (genvar l = 0; l < LO_N; l++) begin : g_col
      assign line[h*LO_N + l] = hi[h] & lo[l];
    end
  end
endmodule

// File: rtl/matrix_line_sel.sv
module matrix_line_sel #(
  parameter int HI_N = 8,
  parameter int LO_N = 8,
  localparam int HI_W   = (HI_N > 1) ? $clog2(HI_N) : 1,
  localparam int LO_W   = (LO_N > 1) ? $clog2(LO_N) : 1,
  localparam int LINES  = HI_N * LO_N,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              drive_en,
  input  logic [HI_N-1:0]   force_hi,
  input  logic [LO_N-1:0]   force_lo,
  input  logic              err_clr,
  output logic [HI_N-1:0]   hi_drv,
  output logic [LO_N-1:0]   lo_drv,
  output logic [LINES-1:0]  line_sel,
  output logic              err_hi,
  output logic              err_lo
);
  // Named internal events for the checker.
  logic [HI_W-1:0] row_idx;
  logic [LO_W-1:0] col_idx;
  logic            hi_multi;
  logic            lo_multi;

  assign row_idx = addr[ADDR_W-1:LO_W];
  assign col_idx = addr[LO_W-1:0];

  mls_group_dec #(.N(HI_N)) u_hi_dec (
    .en(drive_en), .idx(row_idx), .force_v(force_hi), .drv(hi_drv)
  );

  mls_group_dec #(.N(LO_N)) u_lo_dec (
    .en(drive_en), .idx(col_idx), .force_v(force_lo), .drv(lo_drv)
  );

  mls_line_matrix #(.HI_N(HI_N), .LO_N(LO_N)) u_matrix (
    .hi(hi_drv), .lo(lo_drv), .line(line_sel)
  );

  mls_multi_det #(.N(HI_N)) u_hi_det (
    .clk(clk), .rst_n(rst_n), .drv(hi_drv), .clr(err_clr),
    .multi(hi_multi), .err(err_hi)
  );

  mls_multi_det #(.N(LO_N)) u_lo_det (
    .clk(clk), .rst_n(rst_n), .drv(lo_drv), .clr(err_clr),
    .multi(lo_multi), .err(err_lo)
  );
endmodule

// File: rtl/matrix_line_sel_chk.sv
module matrix_line_sel_chk #(
  parameter int HI_N = 8,
  parameter int LO_N = 8,
  localparam int LINES = HI_N * LO_N
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drive_en,
  input logic [HI_N-1:0]  force_hi,
  input logic [LO_N-1:0]  force_lo,
  input logic             err_clr,
  input logic [HI_N-1:0]  hi_drv,
  input logic [LO_N-1:0]  lo_drv,
  input logic [LINES-1:0] line_sel,
  input logic             err_hi,
  input logic             err_lo
);
  logic clean;
  assign clean = drive_en && force_hi == '0 && force_lo == '0;

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> $countones(hi_drv) == 1 && $countones(lo_drv) == 1); // R1
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> $countones(line_sel) == 1); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> hi_drv == '0 && lo_drv == '0 && line_sel == '0); // R3
  AST_FORCE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (hi_drv & force_hi) == force_hi && (lo_drv & force_lo) == force_lo); // R4
  AST_HI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hi_drv) > 1 |=> err_hi); // R5
  AST_LO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lo_drv) > 1 |=> err_lo); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_hi && !err_clr |=> err_hi); // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && $countones(hi_drv) < 2 |=> !err_hi); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !err_lo && $countones(lo_drv) < 2 |=> !err_lo); // R8
endmodule

bind matrix_line_sel matrix_line_sel_chk #(.HI_N(HI_N), .LO_N(LO_N)) u_chk (.*);

// File: tb/matrix_line_sel_tb.sv
module matrix_line_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Default 8x8 instance
  logic [5:0]  a8;
  logic        en8, clr8;
  logic [7:0]  fh8, fl8, hi8, lo8;
  logic [63:0] ls8;
  logic        eh8, el8;

  // 16x8 instance
  logic [6:0]   a16;
  logic         en16;
  logic [15:0]  hi16;
  logic [7:0]   lo16;
  logic [127:0] ls16;
  logic         eh16, el16;

  matrix_line_sel u_dut (
    .clk(clk), .rst_n(rst_n), .addr(a8), .drive_en(en8),
    .force_hi(fh8), .force_lo(fl8), .err_clr(clr8),
    .hi_drv(hi8), .lo_drv(lo8), .line_sel(ls8), .err_hi(eh8), .err_lo(el8)
  );

  matrix_line_sel #(.HI_N(16), .LO_N(8)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .addr(a16), .drive_en(en16),
    .force_hi(16'h0), .force_lo(8'h0), .err_clr(1'b0),
    .hi_drv(hi16), .lo_drv(lo16), .line_sel(ls16), .err_hi(eh16), .err_lo(el16)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    a8 = '0; en8 = 0; clr8 = 0; fh8 = '0; fl8 = '0;
    a16 = '0; en16 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 reset err_hi", 128'(eh8), 128'(0));
    chk("R8 reset err_lo", 128'(el8), 128'(0));

    // R1, R2: exhaustive 8x8 sweep
    en8 = 1;
    for (int a = 0; a < 64; a++) begin
      a8 = 6'(a);
      #1;
      chk("R1 hi_drv", 128'(hi8), 128'(1) << (a / 8));
      chk("R1 lo_drv", 128'(lo8), 128'(1) << (a % 8));
      chk("R2 line_sel", 128'(ls8), 128'(1) << a);
      tick();
    end
    chk("R8 no spurious err_hi", 128'(eh8), 128'(0));
    chk("R8 no spurious err_lo", 128'(el8), 128'(0));

    // R9: exhaustive 16x8 sweep
    en16 = 1;
    for (int a = 0; a < 128; a++) begin
      a16 = 7'(a);
      #1;
      chk("R9 hi_drv", 128'(hi16), 128'(1) << (a / 8));
      chk("R9 lo_drv", 128'(lo16), 128'(1) << (a % 8));
      chk("R9 line_sel", ls16, 128'(1) << a);
    end
    chk("R9 no err", 128'({eh16, el16}), 128'(0));

    // R4 + R5: forced extra row driver
    a8 = 6'd0; fh8 = 8'h02;
    #1;
    chk("R4 forced hi_drv", 128'(hi8), 128'h03);
    chk("R2 forced line_sel", 128'(ls8), 128'h0000_0101);
    chk("R5 not yet latched", 128'(eh8), 128'(0));
    tick();
    chk("R5 err_hi set", 128'(eh8), 128'(1));
    chk("R6 err_lo untouched", 128'(el8), 128'(0));
    fh8 = '0;
    tick();
    tick();
    chk("R7 err_hi held", 128'(eh8), 128'(1));
    clr8 = 1;
    tick();
    clr8 = 0;
    chk("R7 err_hi cleared", 128'(eh8), 128'(0));

    // R6 + R7: column multi-drive colliding with clear, set wins
    a8 = 6'd9; fl8 = 8'h10; clr8 = 1;
    #1;
    chk("R4 forced lo_drv", 128'(lo8), 128'h12);
    tick();
    chk("R7 set wins over clear", 128'(el8), 128'(1));
    chk("R5 err_hi stays low", 128'(eh8), 128'(0));
    fl8 = '0;
    tick();
    clr8 = 0;
    chk("R7 err_lo cleared", 128'(el8), 128'(0));

    // R3: disabled, forces ignored
    en8 = 0; fh8 = 8'hFF; fl8 = 8'hFF; a8 = 6'd45;
    #1;
    chk("R3 hi_drv idle", 128'(hi8), 128'(0));
    chk("R3 lo_drv idle", 128'(lo8), 128'(0));
    chk("R3 line_sel idle", 128'(ls8), 128'(0));
    tick();
    chk("R3 no err while idle", 128'({eh8, el8}), 128'(0));
    fh8 = '0; fl8 = '0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule